// File: doc/BRIEF.md
# Stack Pointer Register Unit

This block holds the stack pointer of a small 8-bit processor core. The pointer is kept in 12 implemented bits and is presented on a 16-bit output that addresses data memory. The upper four bits of that output are always zero. The stack grows toward lower addresses.

The core adjusts the pointer through a 3-bit operation code:
- single-byte data pushes and pops move it by one;
- call-type entries (direct, indirect and relative calls, and interrupt entry) move it down by two;
- returns move it up by two.

Every adjustment takes effect at the next clock edge.

Software sees the pointer as two byte-wide registers on an I/O-style register bus. The low byte sits at a parameterised base address and the high byte at base plus one. Reads are combinational. Writes take effect at the next edge and win over any adjustment requested in the same cycle.

Top module: `stkptr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer becomes 0x04FF. After reset, `sp_addr` reads 0x04FF.
- R2: Operation code 3'd1 (byte push) with no register write in that cycle lowers the pointer by 1 at the next edge.
- R3: Operation code 3'd2 (byte pop) with no register write in that cycle raises the pointer by 1 at the next edge.
- R4: Operation code 3'd3 (call or interrupt entry) with no register write in that cycle lowers the pointer by 2 at the next edge.
- R5: Operation code 3'd4 (return) with no register write in that cycle raises the pointer by 2 at the next edge.
- R6: A write with `bus_we` high at address `BASE_ADDR` loads pointer bits 7:0 from `bus_wdata` and keeps bits 11:8. A read at `BASE_ADDR` returns pointer bits 7:0.
- R7: A write at `BASE_ADDR+1` loads pointer bits 11:8 from `bus_wdata[3:0]`; `bus_wdata[7:4]` is ignored. A read at `BASE_ADDR+1` returns pointer bits 11:8 in bits 3:0 and zero in bits 7:4. `sp_addr[15:12]` is always zero.
- R8: When a register write and an adjustment request fall in the same cycle, the write alone takes effect and the adjustment is dropped.
- R9: Adjustments wrap modulo 4096 within the 12 implemented bits. For example, 0x000 after a byte push is 0xFFF, and 0xFFE after a return is 0x000.
- R10: Writes to any address other than the two pointer addresses leave the pointer unchanged, and reads from such an address return 0x00.
- R11: Operation code 3'd0, and the unused codes 3'd5 to 3'd7, leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| adj_op | input | 3 | Adjustment request: 0 none, 1 push byte, 2 pop byte, 3 call, 4 return |
| sp_addr | output | 16 | Current stack pointer, zero-extended |

## Verification
A wrong pointer state appears on `sp_addr` in the cycle right after the edge that stored it. It also shows on the byte read path in that same cycle, because both views come from one register. Any mistake in step size, direction, wrap or write priority is therefore visible one cycle after the request that caused it. A lost upper-bit mask shows as nonzero bits in the high byte read or in `sp_addr[15:12]`. The bench compares every step of a long mixed sequence against a model, so a deviation is caught at its first occurrence rather than at the end of the sequence.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int BYTE_W = 8;

    // Adjustment request codes seen on adj_op
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PUSH1 = 3'd1,
        OP_POP1  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4
    } sp_op_e;

    // Decoded adjustment: whether to move and by how much (signed)
    typedef struct packed {
        logic              valid;
        logic signed [2:0] delta;
    } sp_step_t;

    function automatic sp_step_t decode_op(input logic [2:0] code);
        sp_step_t s;
        s.valid = 1'b1;
        s.delta = 3'sd0;
        case (sp_op_e'(code))
            OP_PUSH1: s.delta = -3'sd1;
            OP_POP1:  s.delta =  3'sd1;
            OP_CALL:  s.delta = -3'sd2;
            OP_RET:   s.delta =  3'sd2;
            default:  s.valid = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stkptr_bus_port.sv
module stkptr_bus_port
    import stkptr_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                IMPL_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h20
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [IMPL_W-1:0] ptr,
    output logic              wr_en,
    output logic [IMPL_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int                HI_W    = IMPL_W - BYTE_W;
    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_lo, hit_hi;
    logic [BYTE_W-1:0] hi_view;

    assign hit_lo = (bus_addr == BASE_ADDR);
    assign hit_hi = (bus_addr == HI_ADDR);

    // High byte view: implemented bits in the low end, zeros above them
    generate
        if (HI_W == BYTE_W) begin : g_full_hi
            assign hi_view = ptr[IMPL_W-1:BYTE_W];
        end else begin : g_part_hi
            assign hi_view = {{(BYTE_W-HI_W){1'b0}}, ptr[IMPL_W-1:BYTE_W]};
        end
    endgenerate

    // Merge the written byte into the current pointer
    always_comb begin
        wr_en  = bus_we && (hit_lo || hit_hi);
        wr_ptr = ptr;
        if (hit_lo)
            wr_ptr[BYTE_W-1:0] = bus_wdata;
        else if (hit_hi)
            wr_ptr[IMPL_W-1:BYTE_W] = bus_wdata[HI_W-1:0];
    end

    always_comb begin
        if (hit_lo)
            rdata = ptr[BYTE_W-1:0];
        else if (hit_hi)
            rdata = hi_view;
        else
            rdata = '0;
    end

endmodule

// File: rtl/stkptr_step.sv
module stkptr_step
    import stkptr_pkg::*;
#(
    parameter int IMPL_W = 12
) (
    input  logic [IMPL_W-1:0] ptr,
    input  logic [2:0]        op,
    output logic              adj_valid,
    output logic [IMPL_W-1:0] adj_ptr
);
    sp_step_t          step;
    logic [IMPL_W-1:0] delta_ext;

    assign step      = decode_op(op);
    assign adj_valid = step.valid;
    assign delta_ext = {{(IMPL_W-3){step.delta[2]}}, step.delta};
    // Modulo 2^IMPL_W by truncation of the sum
    assign adj_ptr   = ptr + delta_ext;

endmodule

// File: rtl/stkptr_core_reg.sv
module stkptr_core_reg #(
    parameter int                IMPL_W    = 12,
    parameter logic [IMPL_W-1:0] RESET_VAL = 12'h4FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IMPL_W-1:0] wr_ptr,
    input  logic              adj_valid,
    input  logic [IMPL_W-1:0] adj_ptr,
    output logic [IMPL_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= RESET_VAL;
        else if (wr_en)
            ptr <= wr_ptr;      // register write wins
        else if (adj_valid)
            ptr <= adj_ptr;
    end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                PTR_W     = 16,
    parameter int                IMPL_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h20,
    parameter logic [IMPL_W-1:0] RESET_VAL = 12'h4FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [2:0]        adj_op,
    output logic [PTR_W-1:0]  sp_addr
);
    logic [IMPL_W-1:0] ptr;
    logic              wr_en;
    logic [IMPL_W-1:0] wr_ptr;
    logic              adj_valid;
    logic [IMPL_W-1:0] adj_ptr;

    stkptr_bus_port #(
        .ADDR_W(ADDR_W), .IMPL_W(IMPL_W), .BASE_ADDR(BASE_ADDR)
    ) u_bus (
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .ptr(ptr), .wr_en(wr_en), .wr_ptr(wr_ptr), .rdata(bus_rdata)
    );

    stkptr_step #(.IMPL_W(IMPL_W)) u_step (
        .ptr(ptr), .op(adj_op), .adj_valid(adj_valid), .adj_ptr(adj_ptr)
    );

    stkptr_core_reg #(.IMPL_W(IMPL_W), .RESET_VAL(RESET_VAL)) u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .adj_valid(adj_valid), .adj_ptr(adj_ptr), .ptr(ptr)
    );

    generate
        if (PTR_W == IMPL_W) begin : g_no_pad
            assign sp_addr = ptr;
        end else begin : g_pad
            assign sp_addr = {{(PTR_W-IMPL_W){1'b0}}, ptr};
        end
    endgenerate

endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk #(
    parameter int                ADDR_W    = 6,
    parameter int                PTR_W     = 16,
    parameter int                IMPL_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h20,
    parameter logic [IMPL_W-1:0] RESET_VAL = 12'h4FF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [2:0]        adj_op,
    input logic [PTR_W-1:0]  sp_addr
);
    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_wr;
    logic rst_q = 1'b0;

    assign hit_wr = bus_we && (bus_addr == BASE_ADDR || bus_addr == HI_ADDR);

    always_ff @(posedge clk) rst_q <= rst;

    // R1: the edge after reset was sampled shows the reset value
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_value_r1: assert (sp_addr == PTR_W'(RESET_VAL));
        end
    end

    p_push_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (!hit_wr && adj_op == 3'd1) |=>
            sp_addr[IMPL_W-1:0] == $past(sp_addr[IMPL_W-1:0]) - IMPL_W'(1));

    p_pop_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (!hit_wr && adj_op == 3'd2) |=>
            sp_addr[IMPL_W-1:0] == $past(sp_addr[IMPL_W-1:0]) + IMPL_W'(1));

    p_call_r4: assert property (@(posedge clk) disable iff (rst)
        (!hit_wr && adj_op == 3'd3) |=>
            sp_addr[IMPL_W-1:0] == $past(sp_addr[IMPL_W-1:0]) - IMPL_W'(2));

    p_return_r5: assert property (@(posedge clk) disable iff (rst)
        (!hit_wr && adj_op == 3'd4) |=>
            sp_addr[IMPL_W-1:0] == $past(sp_addr[IMPL_W-1:0]) + IMPL_W'(2));

    p_lo_read_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == BASE_ADDR) |-> bus_rdata == sp_addr[7:0]);

    // R8: a low byte write wins over any adjustment in the same cycle
    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == BASE_ADDR) |=>
            (sp_addr[7:0] == $past(bus_wdata) &&
             sp_addr[IMPL_W-1:8] == $past(sp_addr[IMPL_W-1:8])));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!hit_wr && (adj_op == 3'd0 || adj_op > 3'd4)) |=> $stable(sp_addr));

endmodule

bind stkptr_unit stkptr_chk #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .IMPL_W(IMPL_W),
    .BASE_ADDR(BASE_ADDR), .RESET_VAL(RESET_VAL)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adj_op(adj_op),
    .sp_addr(sp_addr)
);

// File: tb/stkptr_unit_bench.sv
`timescale 1ns/1ps
module stkptr_unit_bench;
    localparam logic [5:0] BASE = 6'h20;
    localparam logic [5:0] HI   = 6'h21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  adj_op = 3'd0;
    logic [15:0] sp_addr;

    int checks = 0;
    int errors = 0;
    logic [11:0] model;

    always #2.5 clk = ~clk;

    stkptr_unit #(.BASE_ADDR(BASE)) u_stkptr_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adj_op(adj_op),
        .sp_addr(sp_addr)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] step_model(input logic [11:0] p, input logic [2:0] op);
        case (op)
            3'd1: return p - 12'd1;
            3'd2: return p + 12'd1;
            3'd3: return p - 12'd2;
            3'd4: return p + 12'd2;
            default: return p;
        endcase
    endfunction

    // One cycle: drive at negedge, let one edge pass, sample at next negedge
    task automatic cycle(input logic we, input logic [5:0] a, input logic [7:0] d,
                         input logic [2:0] op);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; adj_op = op;
        @(negedge clk);
        bus_we = 1'b0; adj_op = 3'd0;
    endtask

    task automatic set_ptr(input logic [11:0] v);
        cycle(1'b1, BASE, v[7:0], 3'd0);
        cycle(1'b1, HI, {4'h0, v[11:8]}, 3'd0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset sp", sp_addr, 16'h04FF);
        bus_addr = BASE; #0.1;
        check("R1 reset lo read", {8'h0, bus_rdata}, 16'h00FF);
        bus_addr = HI; #0.1;
        check("R1 reset hi read", {8'h0, bus_rdata}, 16'h0004);
    endtask

    task automatic t_steps();
        set_ptr(12'h400);
        cycle(1'b0, 6'h0, 8'h0, 3'd1);
        check("R2 push byte", sp_addr, 16'h03FF);
        cycle(1'b0, 6'h0, 8'h0, 3'd2);
        check("R3 pop byte", sp_addr, 16'h0400);
        cycle(1'b0, 6'h0, 8'h0, 3'd3);
        check("R4 call", sp_addr, 16'h03FE);
        cycle(1'b0, 6'h0, 8'h0, 3'd4);
        check("R5 return", sp_addr, 16'h0400);
    endtask

    task automatic t_bytes();
        set_ptr(12'h123);
        cycle(1'b1, BASE, 8'hC5, 3'd0);
        check("R6 lo write keeps hi", sp_addr, 16'h01C5);
        bus_addr = BASE; #0.1;
        check("R6 lo read", {8'h0, bus_rdata}, 16'h00C5);
        cycle(1'b1, HI, 8'hFA, 3'd0);
        check("R7 hi write masks upper nibble", sp_addr, 16'h0AC5);
        bus_addr = HI; #0.1;
        check("R7 hi read upper zero", {8'h0, bus_rdata}, 16'h000A);
    endtask

    task automatic t_collide();
        set_ptr(12'h250);
        cycle(1'b1, BASE, 8'h33, 3'd1);
        check("R8 lo write beats push", sp_addr, 16'h0233);
        cycle(1'b1, HI, 8'h07, 3'd3);
        check("R8 hi write beats call", sp_addr, 16'h0733);
    endtask

    task automatic t_wrap();
        set_ptr(12'h000);
        cycle(1'b0, 6'h0, 8'h0, 3'd1);
        check("R9 push wraps low", sp_addr, 16'h0FFF);
        cycle(1'b0, 6'h0, 8'h0, 3'd2);
        check("R9 pop wraps high", sp_addr, 16'h0000);
        set_ptr(12'h001);
        cycle(1'b0, 6'h0, 8'h0, 3'd3);
        check("R9 call wraps low", sp_addr, 16'h0FFF);
        set_ptr(12'hFFE);
        cycle(1'b0, 6'h0, 8'h0, 3'd4);
        check("R9 return wraps high", sp_addr, 16'h0000);
    endtask

    task automatic t_other_addr();
        set_ptr(12'h3A5);
        cycle(1'b1, 6'h22, 8'h11, 3'd0);
        check("R10 foreign write ignored", sp_addr, 16'h03A5);
        cycle(1'b1, 6'h1F, 8'h99, 3'd2);
        check("R10 foreign write lets pop through", sp_addr, 16'h03A6);
        bus_addr = 6'h22; #0.1;
        check("R10 foreign read zero", {8'h0, bus_rdata}, 16'h0000);
    endtask

    task automatic t_idle_codes();
        set_ptr(12'h567);
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            cycle(1'b0, 6'h0, 8'h0, 3'(c));
            check("R11 idle code holds", sp_addr, 16'h0567);
        end
    endtask

    task automatic t_sequence();
        logic [7:0] lfsr = 8'hA7;
        set_ptr(12'h010);
        model = 12'h010;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            op = 3'(lfsr % 8'd6);
            if (lfsr[7:5] == 3'b111) begin
                cycle(1'b1, BASE, lfsr, op);
                model[7:0] = lfsr;
                check("R8 sequence write", sp_addr, {4'h0, model});
            end else begin
                cycle(1'b0, 6'h0, 8'h0, op);
                model = step_model(model, op);
                check("R2 R3 R4 R5 R9 sequence step", sp_addr, {4'h0, model});
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_steps();
        t_bytes();
        t_collide();
        t_wrap();
        t_other_addr();
        t_idle_codes();
        t_sequence();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule